// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

This block is a general-purpose I/O controller for 28 pins. Each pin is either an output, driven from a per-pin output latch, or an input whose level passes through a two-flop synchroniser. Software reaches the controller through a simple word-addressed register bus. Output latch bits are changed with atomic set and clear strobes, so a single pin can change without a read-modify-write.

Input pins can flag rising or falling transitions into a sticky status word. Software clears a status bit by writing a one to it. The status drives eleven dedicated interrupt lines for the low pins and one shared line for all remaining pins. A further register holds an alternate-function selection that is stored and read back but has no effect inside this block.

Register word offsets (byte address, bits 1:0 must be zero, otherwise the access is ignored and reads zero): 0x00 pin level, 0x04 direction, 0x08 output set, 0x0C output clear, 0x10 rising enable, 0x14 falling enable, 0x18 edge status, 0x1C alternate function. In every register, bit n belongs to pin n. Bits 31:28 read as zero.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: While reset is low, and after it is released, direction, output latch, both enables, status and alternate function are zero, pin_oe and all interrupt lines are low, and every register reads zero while the pins are low.
- R2: A write to 0x04 stores bits 27:0 as the direction, where 1 makes the pin an output; pin_oe equals the stored direction.
- R3: A write to 0x08 sets every latch bit whose data bit is 1 and leaves the other bits unchanged; 0x08 reads as zero.
- R4: A write to 0x0C clears every latch bit whose data bit is 1 and leaves the other bits unchanged; 0x0C reads as zero.
- R5: pin_out is the output latch ANDed with direction, so a pin with direction 0 drives 0.
- R6: A read of 0x00 returns the latch bit for output pins and the synchronised input for input pins; an input change shows there two clock edges after it is sampled.
- R7: A status bit (0x18) sets when its synchronised input goes from 0 to 1 while its rising-enable bit (0x10) is 1; with the enable at 0 the rise leaves it unchanged.
- R8: A status bit sets when its synchronised input goes from 1 to 0 while its falling-enable bit (0x14) is 1.
- R9: No status bit sets for a pin whose direction is 1, and turning a pin back into an input with a steady level creates no edge.
- R10: Status bits stay set until a write to 0x18 with a 1 in that bit position; 0 bits in that write leave them unchanged.
- R11: When an edge and a clearing write to the same status bit act on the same clock edge, the bit stays set.
- R12: irq_pin[n] follows status bit n for n from 0 to 10; irq_rest is high when any of status bits 27:11 is set.
- R13: A write to 0x1C stores bits 27:0 as the alternate-function value, which reads back unchanged and affects no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | 28 | Pin levels from the pads (asynchronous) |
| pin_out | output | 28 | Output value, latch AND direction |
| pin_oe | output | 28 | Output enable per pin (the direction) |
| irq_pin | output | 11 | Dedicated interrupt for each of pins 0 to 10 |
| irq_rest | output | 1 | Combined interrupt for pins 11 to 27 |

## Verification
The bench goes after the collision of a fresh edge with a clearing write on the same edge. A design that lets the clear win would lose that event, and the status would read zero. It also toggles an output pin's pad level with its rising enable set and then turns the pin back into an input. A design that ignored direction, or compared against a stale sample, would report an edge that never happened. Further directed cases check the following: a rise on a pin with only the falling enable set, write-one-to-clear with mixed zero and one bits, pins on both sides of the direct/shared interrupt split, and the level read choosing latch or pad per pin.

// File: rtl/gpio_pkg.sv
// Shared definitions for the edge-detecting GPIO controller.
// Assumes word-aligned byte addresses; the word index selects a register.
package gpio_pkg;
    typedef enum logic [2:0] {
        RG_LEVEL = 3'd0,
        RG_DIR   = 3'd1,
        RG_SET   = 3'd2,
        RG_CLR   = 3'd3,
        RG_RISE  = 3'd4,
        RG_FALL  = 3'd5,
        RG_STAT  = 3'd6,
        RG_ALT   = 3'd7
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for the pad inputs.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_sync #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Capture pads, then resample to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_regfile.sv
// Register bank: direction, output latch, edge enables, alternate function,
// and the read multiplexer. Produces the clear mask for the status word.
// Assumes NPINS < DW; misaligned accesses are ignored.
module gpio_regfile import gpio_pkg::*; #(
    parameter int NPINS = 28,
    parameter int DW    = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [NPINS-1:0] sync_q,
    input  logic [NPINS-1:0] stat_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] latch_q,
    output logic [NPINS-1:0] rise_q,
    output logic [NPINS-1:0] fall_q,
    output logic [NPINS-1:0] clr_mask
);
    localparam int IW = AW - 2;

    logic              aligned;
    logic [IW-1:0]     idx;
    logic [NPINS-1:0]  wd;
    logic [NPINS-1:0]  alt_q;
    logic [NPINS-1:0]  level;
    logic              unused_hi;
    logic              wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_stat, wr_alt;

    assign aligned   = (reg_addr[1:0] == 2'b00);
    assign idx       = reg_addr[AW-1:2];
    assign wd        = reg_wdata[NPINS-1:0];
    assign unused_hi = ^reg_wdata[DW-1:NPINS];

    // Decode one write strobe per register.
    assign wr_dir  = reg_wr && aligned && (idx == RG_DIR);
    assign wr_set  = reg_wr && aligned && (idx == RG_SET);
    assign wr_clr  = reg_wr && aligned && (idx == RG_CLR);
    assign wr_rise = reg_wr && aligned && (idx == RG_RISE);
    assign wr_fall = reg_wr && aligned && (idx == RG_FALL);
    assign wr_stat = reg_wr && aligned && (idx == RG_STAT);
    assign wr_alt  = reg_wr && aligned && (idx == RG_ALT);

    assign clr_mask = wr_stat ? wd : '0;
    assign level    = (latch_q & dir_q) | (sync_q & ~dir_q);

    // Update configuration registers and the output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            alt_q   <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wd;
            if (wr_rise) rise_q <= wd;
            if (wr_fall) fall_q <= wd;
            if (wr_alt)  alt_q  <= wd;
            if (wr_set)      latch_q <= latch_q | wd;
            else if (wr_clr) latch_q <= latch_q & ~wd;
        end
    end

    // Select the read value; strobe registers and bad offsets give zero.
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            case (idx)
                RG_LEVEL: reg_rdata[NPINS-1:0] = level;
                RG_DIR:   reg_rdata[NPINS-1:0] = dir_q;
                RG_RISE:  reg_rdata[NPINS-1:0] = rise_q;
                RG_FALL:  reg_rdata[NPINS-1:0] = fall_q;
                RG_STAT:  reg_rdata[NPINS-1:0] = stat_q;
                RG_ALT:   reg_rdata[NPINS-1:0] = alt_q;
                default:  reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_edge_det.sv
// Edge detector and sticky status word.
// Assumes sync_q is already synchronous; a new edge beats a same-cycle clear.
module gpio_edge_det #(
    parameter int NPINS = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sync_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] rise_q,
    input  logic [NPINS-1:0] fall_q,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] stat_q
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] rise_ev;
    logic [NPINS-1:0] fall_ev;

    assign rise_ev =  sync_q & ~prev_q & rise_q & ~dir_q;
    assign fall_ev = ~sync_q &  prev_q & fall_q & ~dir_q;

    // Keep the previous sample and accumulate status, edges dominating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= sync_q;
            stat_q <= (stat_q & ~clr_mask) | rise_ev | fall_ev;
        end
    end
endmodule

// File: rtl/gpio_irq_fan.sv
// Interrupt fan-out: one line per low pin, one OR-ed line for the rest.
// Assumes NDIRECT < NPINS.
module gpio_irq_fan #(
    parameter int NPINS   = 28,
    parameter int NDIRECT = 11
) (
    input  logic [NPINS-1:0]   stat_q,
    output logic [NDIRECT-1:0] irq_pin,
    output logic               irq_rest
);
    for (genvar i = 0; i < NDIRECT; i++) begin : g_direct
        assign irq_pin[i] = stat_q[i];
    end

    assign irq_rest = |stat_q[NPINS-1:NDIRECT];
endmodule

// File: rtl/edge_gpio_ctrl.sv
// Top of the edge-detecting GPIO controller: synchroniser, register bank,
// edge detector and interrupt fan-out.
// Assumes a single clock domain for the register bus; pads are asynchronous.
module edge_gpio_ctrl #(
    parameter int NPINS   = 28,
    parameter int NDIRECT = 11,
    parameter int DW      = 32,
    parameter int AW      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe,
    output logic [NDIRECT-1:0] irq_pin,
    output logic               irq_rest
);
    logic [NPINS-1:0] sync_q, dir_q, latch_q, rise_q, fall_q, stat_q, clr_mask;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
    );

    gpio_regfile #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_q(sync_q),
        .stat_q(stat_q), .dir_q(dir_q), .latch_q(latch_q), .rise_q(rise_q),
        .fall_q(fall_q), .clr_mask(clr_mask)
    );

    gpio_edge_det #(.NPINS(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .dir_q(dir_q),
        .rise_q(rise_q), .fall_q(fall_q), .clr_mask(clr_mask), .stat_q(stat_q)
    );

    gpio_irq_fan #(.NPINS(NPINS), .NDIRECT(NDIRECT)) u_irq (
        .stat_q(stat_q), .irq_pin(irq_pin), .irq_rest(irq_rest)
    );

    assign pin_out = latch_q & dir_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/edge_gpio_chk.sv
// Assertion checker for edge_gpio_ctrl, attached by bind below.
// Assumes the word offsets listed in gpio_pkg.
module edge_gpio_chk import gpio_pkg::*; #(
    parameter int NPINS   = 28,
    parameter int NDIRECT = 11,
    parameter int DW      = 32,
    parameter int AW      = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [AW-1:0]      reg_addr,
    input logic [DW-1:0]      reg_wdata,
    input logic [DW-1:0]      reg_rdata,
    input logic [NPINS-1:0]   pin_out,
    input logic [NPINS-1:0]   pin_oe,
    input logic [NDIRECT-1:0] irq_pin,
    input logic               irq_rest,
    input logic [NPINS-1:0]   dir_q,
    input logic [NPINS-1:0]   latch_q,
    input logic [NPINS-1:0]   stat_q
);
    logic             at_set, at_clr, at_stat;
    logic [NPINS-1:0] wmask, sclr;

    assign at_set  = (reg_addr[1:0] == 2'b00) && (reg_addr[AW-1:2] == RG_SET);
    assign at_clr  = (reg_addr[1:0] == 2'b00) && (reg_addr[AW-1:2] == RG_CLR);
    assign at_stat = (reg_addr[1:0] == 2'b00) && (reg_addr[AW-1:2] == RG_STAT);
    assign wmask   = reg_wdata[NPINS-1:0];
    assign sclr    = (reg_wr && at_stat) ? wmask : '0;

    AST_OUT_GATED_BY_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0); // R5
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_pin == '0 && !irq_rest && pin_oe == '0)); // R1
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && at_set) |=> ((latch_q & $past(wmask)) == $past(wmask))); // R3
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && at_clr) |=> ((latch_q & $past(wmask)) == '0)); // R4
    AST_STROBES_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (at_set || at_clr) |-> (reg_rdata == '0)); // R3
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_q) & ~stat_q & ~$past(sclr)) == '0); // R10
    AST_NO_EDGE_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~$past(stat_q) & $past(dir_q)) == '0); // R9
    AST_SHARED_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rest |-> ($countones(stat_q) > $countones(irq_pin))); // R12
endmodule

bind edge_gpio_ctrl edge_gpio_chk #(
    .NPINS(NPINS), .NDIRECT(NDIRECT), .DW(DW), .AW(AW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_pin(irq_pin), .irq_rest(irq_rest),
    .dir_q(dir_q), .latch_q(latch_q), .stat_q(stat_q)
);

// File: tb/edge_gpio_ctrl_tb_top.sv
// Self-checking bench: vector table for register behaviour, then directed
// tests for edges, interrupts, collisions and reset.
module edge_gpio_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [27:0] pin_in = '0;
    logic [27:0] pin_out, pin_oe;
    logic [10:0] irq_pin;
    logic        irq_rest;
    int          nchk = 0;
    int          nerr = 0;

    always #4 clk = ~clk;

    edge_gpio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin(irq_pin), .irq_rest(irq_rest)
    );

    typedef struct packed {
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [4:0]  raddr;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{5'h04, 32'hFFFF_FFFF, 5'h04, 32'h0FFF_FFFF, 4'd2},  // R2 masked
        '{5'h08, 32'h0000_00F0, 5'h00, 32'h0000_00F0, 4'd3},  // R3 set
        '{5'h0C, 32'h0000_0030, 5'h00, 32'h0000_00C0, 4'd4},  // R4 clear
        '{5'h08, 32'hFFFF_FFFF, 5'h08, 32'h0000_0000, 4'd3},  // R3 reads zero
        '{5'h0C, 32'h0F00_0000, 5'h0C, 32'h0000_0000, 4'd4},  // R4 reads zero
        '{5'h10, 32'hFFFF_FFFF, 5'h10, 32'h0FFF_FFFF, 4'd7},  // R7 enable
        '{5'h14, 32'h0000_1234, 5'h14, 32'h0000_1234, 4'd8},  // R8 enable
        '{5'h1C, 32'hA5A5_A5A5, 5'h1C, 32'h05A5_A5A5, 4'd13}, // R13
        '{5'h04, 32'h0000_FFFF, 5'h00, 32'h0000_FFFF, 4'd6}   // R6 mixed
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got hung expected finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int k = 0; k < 8; k++) begin
            rd(5'(k * 4), v);
            chk($sformatf("R1 reg %0d in reset", k), v, 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pin_oe", {4'h0, pin_oe}, 32'h0);
        chk("R1 irqs", {20'h0, irq_rest, irq_pin}, 32'h0);

        // Vector table
        for (int i = 0; i < 9; i++) begin
            wr(VECS[i].waddr, VECS[i].wdata);
            rd(VECS[i].raddr, v);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
        end

        // R5 / R2: outputs gated by direction
        chk("R5 pin_out", {4'h0, pin_out}, 32'h0000_FFFF);
        chk("R2 pin_oe", {4'h0, pin_oe}, 32'h0000_FFFF);
        wr(5'h04, 32'h0);
        wr(5'h10, 32'h0010_0001);
        wr(5'h14, 32'h0000_0002);
        chk("R5 pin_out all inputs", {4'h0, pin_out}, 32'h0);
        rd(5'h18, v); chk("R7 no edges yet", v, 32'h0);

        // R7 rising on pin 0
        pin_in[0] = 1'b1; settle();
        rd(5'h18, v); chk("R7 rise pin0", v, 32'h1);
        chk("R12 irq_pin pin0", {21'h0, irq_pin}, 32'h1);
        rd(5'h00, v); chk("R6 input level", v, 32'h1);

        // R7 disabled rise, R8 falling on pin 1
        pin_in[1] = 1'b1; settle();
        rd(5'h18, v); chk("R7 rise not enabled", v, 32'h1);
        pin_in[1] = 1'b0; settle();
        rd(5'h18, v); chk("R8 fall pin1", v, 32'h3);

        // R10 sticky and write-one-to-clear
        pin_in[0] = 1'b0; settle();
        rd(5'h18, v); chk("R10 sticky", v, 32'h3);
        wr(5'h18, 32'h0);
        rd(5'h18, v); chk("R10 zero write", v, 32'h3);
        wr(5'h18, 32'h1);
        rd(5'h18, v); chk("R10 clear bit0", v, 32'h2);
        wr(5'h18, 32'h2);
        rd(5'h18, v); chk("R10 clear bit1", v, 32'h0);
        chk("R12 irq_pin cleared", {21'h0, irq_pin}, 32'h0);

        // R12 shared line for upper pins
        pin_in[20] = 1'b1; settle();
        chk("R12 irq_rest set", {31'h0, irq_rest}, 32'h1);
        chk("R12 irq_pin quiet", {21'h0, irq_pin}, 32'h0);
        wr(5'h18, 32'h0010_0000);
        chk("R12 irq_rest cleared", {31'h0, irq_rest}, 32'h0);

        // R9 no edges on output pins, and no edge on turning back to input
        wr(5'h04, 32'h4);
        wr(5'h10, 32'h0010_0005);
        wr(5'h0C, 32'h4);
        pin_in[2] = 1'b1; settle();
        rd(5'h18, v); chk("R9 output pin edge ignored", v, 32'h0);
        rd(5'h00, v); chk("R6 level latch vs pad", v, 32'h0010_0000);
        wr(5'h04, 32'h0); settle();
        rd(5'h18, v); chk("R9 back to input no edge", v, 32'h0);

        // R11 edge and clear on the same edge
        pin_in[0] = 1'b1; settle();
        pin_in[0] = 1'b0; settle();
        rd(5'h18, v); chk("R11 prior bit set", v, 32'h1);
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 5'h18; reg_wdata = 32'h1;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
        rd(5'h18, v); chk("R11 edge wins over clear", v, 32'h1);

        // R1 reset in mid-run
        wr(5'h04, 32'h00F0_000F);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pin_oe after reset", {4'h0, pin_oe}, 32'h0);
        rd(5'h18, v); chk("R1 status after reset", v, 32'h0);
        rd(5'h1C, v); chk("R1 alt after reset", v, 32'h0);
        chk("R1 irqs after reset", {20'h0, irq_rest, irq_pin}, 32'h0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule